// File: doc/BRIEF.md
# Flash program/erase status register

This block holds the status byte of a NOR-flash-style command controller and tracks program/erase suspension. It watches the busy and paused handshake of the program/erase controller. It also takes the suspend, resume, clear-status, read-status and read-array command strobes, plus error event pulses. From these it builds an 8-bit status byte. Some bits follow the device state directly. The error bits are sticky and stay set until software clears them.

The byte reaches the bus through a read latch. The latch takes a snapshot when a read begins, which is when chip enable and output enable are first both low. It keeps that value frozen until the read ends. The block also tells the read path whether a bus read should return the status byte or array data. A new program or erase command is flagged as rejected while any error bit is set.

Top module: `flash_status_reg`

## Requirements
- R1: After the active-low asynchronous reset, the status output is 0x80, the status-select output is 0 and the reject output is 0.
- R2: Bit 7 (ready) is 0 from one clock after the controller busy input rises. It is 1 again one clock after busy falls, when no suspend is pending.
- R3: After a suspend command during an operation, bit 7 stays 0 until the paused input is seen. One clock later bit 7 is 1, and one of two flags is 1: bit 6 if the running operation is an erase (op_erase_i high when it started), or bit 2 if it is a program. The other flag stays 0.
- R4: A resume command while suspended clears bits 6 and 2 and drives bit 7 to 0 one clock later.
- R5: If busy falls after a suspend command but before paused is seen, the block returns to idle. Bit 7 becomes 1 and bits 6 and 2 stay 0.
- R6: The error event bus maps to fixed sticky bits, each event setting only its own bit: event bit 0 (erase failure) sets status bit 5, event bit 1 (program failure) sets bit 4, event bit 2 (supply fault) sets bit 3, and event bit 3 (protected block) sets bit 1. A set bit stays set until it is cleared.
- R7: A clear-status command clears all error bits one clock later. An event arriving in the same cycle as the clear leaves its own bit set.
- R8: A program/erase command while any error bit is set pulses the reject output one clock later and leaves the error bits unchanged. With no error bit set, the reject output stays 0.
- R9: The status output tracks the live byte while no read is active. It is captured at the clock where chip enable and output enable first are both low, and it stays stable until one of them goes high.
- R10: The status-select output is 1 while an operation runs (bit 7 is 0 and the controller is not paused) or after a read-status command. It is 0 after a read-array command when idle, and always 0 while the burst input is high.
- R11: Bit 0 follows the other-bank busy input one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous hardware reset |
| pec_busy_i | input | 1 | Program/erase controller running |
| pec_paused_i | input | 1 | Controller has paused after a suspend |
| op_erase_i | input | 1 | Operation being started is an erase (0: program) |
| cmd_suspend_i | input | 1 | Suspend command strobe |
| cmd_resume_i | input | 1 | Resume command strobe |
| cmd_clear_i | input | 1 | Clear-status command strobe |
| cmd_read_status_i | input | 1 | Read-status command strobe |
| cmd_read_array_i | input | 1 | Read-array command strobe |
| cmd_prog_erase_i | input | 1 | New program or erase command strobe |
| err_evt_i | input | 4 | Error event pulses: [0] erase, [1] program, [2] supply, [3] protect |
| other_bank_busy_i | input | 1 | Another bank is busy |
| ce_ni | input | 1 | Chip enable, active low |
| oe_ni | input | 1 | Output enable, active low |
| burst_i | input | 1 | Current read is a burst |
| status_o | output | 8 | Latched status byte |
| status_sel_o | output | 1 | Bus read returns status instead of array |
| cmd_reject_o | output | 1 | Program/erase command rejected due to pending error |

## Verification
A table of error event masks is tried: single events, pairs and all four at once. This shows the bit mapping and separates a bit that is set on its own from one set along with a neighbour. Directed sequences drive the suspend handshake in three ways: a suspend that reaches paused, a suspend that is overtaken by completion, and a resume. These are run for both erase and program, which separates bit 6 from bit 2 and the late-suspend path from the paused path. Further sequences cover an error event in the same cycle as a clear, and a program/erase command with and without an error pending. The last group holds a read open while the live byte changes, and toggles the read-status, read-array and burst controls.

// File: rtl/fsr_pkg.sv
package fsr_pkg;
  localparam int STAT_W    = 8;
  localparam int NUM_ERR   = 4;
  localparam int BIT_READY = 7;
  localparam int BIT_ESUS  = 6;
  localparam int BIT_PSUS  = 2;
  localparam int BIT_OBANK = 0;
  // event index -> status bit: erase, program, supply, protect
  localparam int ERR_POS [NUM_ERR] = '{5, 4, 3, 1};
  localparam logic [STAT_W-1:0] STAT_RST = 8'h80;

  typedef enum logic [1:0] {
    SUS_IDLE,
    SUS_RUN,
    SUS_PEND,
    SUS_HOLD
  } sus_state_e;
endpackage

// File: rtl/fsr_err_flags.sv
module fsr_err_flags #(
  parameter int N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] evt_i,
  input  logic         clr_i,
  input  logic         pe_cmd_i,
  output logic [N-1:0] flags_o,
  output logic         reject_o
);
  logic [N-1:0] flags_q;
  logic         reject_q;

  for (genvar g = 0; g < N; g++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) flags_q[g] <= 1'b0;
      else         flags_q[g] <= (flags_q[g] & ~clr_i) | evt_i[g];
    end

    assert_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flags_q[g] && !clr_i) |=> flags_o[g]);
    assert_own_bit_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!flags_q[g] && !evt_i[g]) |=> !flags_o[g]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) reject_q <= 1'b0;
    else         reject_q <= pe_cmd_i & (|flags_q);
  end

  assign flags_o  = flags_q;
  assign reject_o = reject_q;

  assert_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && evt_i == '0) |=> flags_o == '0);
  assert_reject_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pe_cmd_i && flags_o != '0) |=> reject_o);
  assert_reject_keep_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pe_cmd_i && !clr_i && evt_i == '0) |=> $stable(flags_o));
endmodule

// File: rtl/fsr_susp_track.sv
module fsr_susp_track
  import fsr_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic busy_i,
  input  logic paused_i,
  input  logic op_erase_i,
  input  logic suspend_i,
  input  logic resume_i,
  output logic ready_o,
  output logic esus_o,
  output logic psus_o,
  output logic op_active_o
);
  sus_state_e state_q, state_d;
  logic       erase_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SUS_IDLE: if (busy_i) state_d = SUS_RUN;
      SUS_RUN: begin
        if (suspend_i)    state_d = SUS_PEND;
        else if (!busy_i) state_d = SUS_IDLE;
      end
      SUS_PEND: begin
        if (paused_i)     state_d = SUS_HOLD;
        else if (!busy_i) state_d = SUS_IDLE; // finished inside suspend latency
      end
      SUS_HOLD: if (resume_i) state_d = SUS_RUN;
      default: state_d = SUS_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SUS_IDLE;
      erase_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == SUS_IDLE && busy_i) erase_q <= op_erase_i;
    end
  end

  assign ready_o     = (state_q == SUS_IDLE) || (state_q == SUS_HOLD);
  assign esus_o      = (state_q == SUS_HOLD) && erase_q;
  assign psus_o      = (state_q == SUS_HOLD) && !erase_q;
  assign op_active_o = !ready_o;

  assert_pend_busy_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == SUS_PEND && !paused_i && busy_i) |=> !ready_o);
  assert_resume_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == SUS_HOLD && resume_i) |=> (!esus_o && !psus_o && !ready_o));
  assert_late_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == SUS_PEND && !paused_i && !busy_i) |=> (ready_o && !esus_o && !psus_o));
  assert_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({esus_o, psus_o}));
endmodule

// File: rtl/fsr_read_latch.sv
module fsr_read_latch #(
  parameter int                W       = 8,
  parameter logic [W-1:0]      RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ce_ni,
  input  logic         oe_ni,
  input  logic [W-1:0] live_i,
  output logic [W-1:0] status_o
);
  logic         active, active_q;
  logic [W-1:0] status_q;

  assign active = !ce_ni && !oe_ni;

  // track live byte until a read is under way; first active clock captures
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      status_q <= RST_VAL;
    end else begin
      active_q <= active;
      if (!active_q) status_q <= live_i;
    end
  end

  assign status_o = status_q;

  assert_freeze_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && active) |=> $stable(status_o));
  assert_track_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_q |=> status_o == $past(live_i));
endmodule

// File: rtl/flash_status_reg.sv
module flash_status_reg
  import fsr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pec_busy_i,
  input  logic              pec_paused_i,
  input  logic              op_erase_i,
  input  logic              cmd_suspend_i,
  input  logic              cmd_resume_i,
  input  logic              cmd_clear_i,
  input  logic              cmd_read_status_i,
  input  logic              cmd_read_array_i,
  input  logic              cmd_prog_erase_i,
  input  logic [NUM_ERR-1:0] err_evt_i,
  input  logic              other_bank_busy_i,
  input  logic              ce_ni,
  input  logic              oe_ni,
  input  logic              burst_i,
  output logic [STAT_W-1:0] status_o,
  output logic              status_sel_o,
  output logic              cmd_reject_o
);
  logic [NUM_ERR-1:0] flags;
  logic               ready, esus, psus, op_active;
  logic               obank_q, rs_mode_q;
  logic [STAT_W-1:0]  live;

  fsr_err_flags #(.N(NUM_ERR)) u_err (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .evt_i    (err_evt_i),
    .clr_i    (cmd_clear_i),
    .pe_cmd_i (cmd_prog_erase_i),
    .flags_o  (flags),
    .reject_o (cmd_reject_o)
  );

  fsr_susp_track u_sus (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .busy_i      (pec_busy_i),
    .paused_i    (pec_paused_i),
    .op_erase_i  (op_erase_i),
    .suspend_i   (cmd_suspend_i),
    .resume_i    (cmd_resume_i),
    .ready_o     (ready),
    .esus_o      (esus),
    .psus_o      (psus),
    .op_active_o (op_active)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      obank_q   <= 1'b0;
      rs_mode_q <= 1'b0;
    end else begin
      obank_q <= other_bank_busy_i;
      if (cmd_read_status_i)     rs_mode_q <= 1'b1;
      else if (cmd_read_array_i) rs_mode_q <= 1'b0;
    end
  end

  always_comb begin
    live            = '0;
    live[BIT_READY] = ready;
    live[BIT_ESUS]  = esus;
    live[BIT_PSUS]  = psus;
    live[BIT_OBANK] = obank_q;
    for (int i = 0; i < NUM_ERR; i++) live[ERR_POS[i]] = flags[i];
  end

  fsr_read_latch #(.W(STAT_W), .RST_VAL(STAT_RST)) u_rd (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ce_ni    (ce_ni),
    .oe_ni    (oe_ni),
    .live_i   (live),
    .status_o (status_o)
  );

  assign status_sel_o = !burst_i && (rs_mode_q || op_active);

  always_comb begin
    if (rst_ni && burst_i) assert_no_burst_R10: assert (!status_sel_o);
  end

  assert_busy_sel_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ready && !burst_i) |-> status_sel_o);
endmodule

// File: tb/flash_status_reg_tb_top.sv
module flash_status_reg_tb_top;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic busy = 0, paused = 0, op_erase = 0, sus = 0, res = 0, clr = 0;
  logic rds = 0, rda = 0, pe = 0, obank = 0, ce_n = 1, oe_n = 1, burst = 0;
  logic [3:0] evt = '0;
  logic [7:0] status;
  logic sel, rej;
  int checks = 0, errors = 0;
  logic [7:0] v, v1;

  always #4 clk = ~clk;

  flash_status_reg dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .pec_busy_i(busy), .pec_paused_i(paused),
    .op_erase_i(op_erase), .cmd_suspend_i(sus), .cmd_resume_i(res),
    .cmd_clear_i(clr), .cmd_read_status_i(rds), .cmd_read_array_i(rda),
    .cmd_prog_erase_i(pe), .err_evt_i(evt), .other_bank_busy_i(obank),
    .ce_ni(ce_n), .oe_ni(oe_n), .burst_i(burst), .status_o(status),
    .status_sel_o(sel), .cmd_reject_o(rej)
  );

  // {event mask, expected error bits}
  localparam logic [11:0] VEC [8] = '{
    {4'h1, 8'h20}, {4'h2, 8'h10}, {4'h4, 8'h08}, {4'h8, 8'h02},
    {4'h5, 8'h28}, {4'hA, 8'h12}, {4'hF, 8'h3A}, {4'h0, 8'h00}
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd(output logic [7:0] val);
    ce_n = 0; oe_n = 0;
    tick(1);
    val = status;
    ce_n = 1; oe_n = 1;
    tick(2);
  endtask

  task automatic pulse_clr();
    clr = 1; tick(1); clr = 0; tick(1);
  endtask

  initial begin
    #(8 * 100000);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    tick(2);
    chk("R1 reset status", status, 8'h80);
    chk("R1 reset sel", {7'b0, sel}, 8'h00);
    chk("R1 reset reject", {7'b0, rej}, 8'h00);
    rst_ni = 1;
    tick(2);
    chk("R1 after release", status, 8'h80);

    // error mapping table
    for (int i = 0; i < 8; i++) begin
      pulse_clr();
      evt = VEC[i][11:8]; tick(1); evt = '0; tick(1);
      rd(v);
      chk("R6 error map", v & 8'h3A, VEC[i][7:0]);
    end
    pulse_clr(); tick(1);
    rd(v); chk("R7 clear", v & 8'h3A, 8'h00);

    // clear with simultaneous event
    evt = 4'h1; tick(1); evt = '0; tick(1);
    clr = 1; evt = 4'h2; tick(1); clr = 0; evt = '0; tick(1);
    rd(v); chk("R7 clear vs event", v & 8'h3A, 8'h10);
    pulse_clr(); tick(1);

    // other bank
    obank = 1; tick(2);
    rd(v); chk("R11 bit0 high", v & 8'h01, 8'h01);
    obank = 0; tick(2);
    rd(v); chk("R11 bit0 low", v & 8'h01, 8'h00);

    // erase, suspend, pause, resume
    busy = 1; op_erase = 1; tick(2);
    chk("R10 sel while busy", {7'b0, sel}, 8'h01);
    rd(v); chk("R2 busy ready low", v & 8'h80, 8'h00);
    sus = 1; tick(1); sus = 0; tick(3);
    rd(v); chk("R3 pending ready low", v & 8'h80, 8'h00);
    paused = 1; tick(2);
    rd(v); chk("R3 erase suspended", v & 8'hC4, 8'hC0);
    chk("R10 sel idle suspended", {7'b0, sel}, 8'h00);
    paused = 0; res = 1; tick(1); res = 0; tick(1);
    rd(v); chk("R4 resume", v & 8'h84, 8'h00);
    busy = 0; tick(2);
    rd(v); chk("R2 done ready", v, 8'h80);

    // program suspend
    busy = 1; op_erase = 0; tick(2);
    sus = 1; tick(1); sus = 0; tick(1);
    paused = 1; tick(2);
    rd(v); chk("R3 program suspended", v & 8'hC4, 8'h84);
    paused = 0; res = 1; tick(1); res = 0; tick(1);
    rd(v); chk("R4 resume program", v & 8'h84, 8'h00);
    busy = 0; tick(2);

    // late suspend
    busy = 1; op_erase = 1; tick(2);
    sus = 1; tick(1); sus = 0; tick(1);
    busy = 0; tick(2);
    rd(v); chk("R5 late suspend", v & 8'hC4, 8'h80);

    // reject
    evt = 4'h1; tick(1); evt = '0; tick(1);
    pe = 1; tick(1); pe = 0;
    chk("R8 reject pulse", {7'b0, rej}, 8'h01);
    tick(1);
    rd(v); chk("R8 errors kept", v & 8'h3A, 8'h20);
    pulse_clr(); tick(1);
    pe = 1; tick(1); pe = 0;
    chk("R8 no reject", {7'b0, rej}, 8'h00);
    tick(1);

    // read freeze
    ce_n = 0; tick(1); oe_n = 0; tick(1);
    v1 = status;
    evt = 4'h4; tick(1); evt = '0; tick(3);
    chk("R9 frozen", status, v1);
    oe_n = 1; tick(2);
    chk("R9 tracks after read", status & 8'h08, 8'h08);
    ce_n = 1; pulse_clr(); tick(1);

    // read status mode and burst
    rds = 1; tick(1); rds = 0;
    chk("R10 status mode sel", {7'b0, sel}, 8'h01);
    burst = 1; #1;
    chk("R10 burst sel", {7'b0, sel}, 8'h00);
    burst = 0; tick(1);
    rda = 1; tick(1); rda = 0;
    chk("R10 read array sel", {7'b0, sel}, 8'h00);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule